// File: doc/BRIEF.md
# Page Entry Accessed/Dirty Updater

This block runs after an address-translation walk has finished and passed its permission checks. It takes the table entries the walk latched, one for each table level, with the physical address each was read from. It then sets the Accessed flag and, where required, the Dirty flag in table memory. It starts at the leaf level and climbs one level at a time to the top-level entry. An entry whose flags would not change costs no memory traffic.

For an entry whose flags do change, the latched copy is updated at once. Memory is updated through a single compare-and-swap transaction. The memory returns the value it held before the operation, and the write counts as done only if that value equals the entry the walk read. If another agent changed the entry in the meantime, memory is left as that agent wrote it and no write is reported. A per-level mark records each write that succeeded, so that a dirty-page log can record the table pages that were modified.

Top module: `pte_ad_updater`

## Requirements
- R1: The new value of an entry is its latched value OR the Accessed flag (bit 5), plus OR the Dirty flag (bit 6) when Dirty is requested for that entry. No other bit differs between the compare and swap values of a request.
- R2: An entry whose new value equals its latched value issues no memory request, keeps its latched value and leaves its `wrote` bit at 0.
- R3: An entry whose new value differs from its latched value has its latched copy (`ent_out`) set to the new value, whether or not the compare-and-swap succeeds.
- R4: Each changed entry issues exactly one compare-and-swap request: `req_addr` is the entry's address, `req_cmp` its latched value and `req_swap` its new value. The request counts as successful only when `rsp_data` equals `req_cmp`.
- R5: When `walk_ok` is 0 at `start`, no request is issued, `ent_out` equals `ent_in`, `wrote` is all zero and `done` still pulses.
- R6: Levels are processed in increasing order, from the leaf level (`leaf_lvl`, where 0 is the lowest table) up to the top level (index LEVELS-1). At most one request is outstanding at a time, and the block waits for its response before it moves on.
- R7: Dirty is requested only when `is_write` is 1 and the level equals `leaf_lvl`. The top-level entry never receives Dirty, even when it is the leaf.
- R8: `wrote[l]` is set when the request for level l succeeds. It is cleared at the next accepted `start`, and at most one bit rises in any cycle.
- R9: `req_valid` and the request fields stay stable from the cycle they are raised until the cycle `rsp_valid` is seen.
- R10: `done` is high for exactly one cycle at the end of each operation. `busy` is high from the cycle after `start` until and including the `done` cycle. A `start` while `busy` is ignored, and no request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an update; accepted only when idle |
| walk_ok | input | 1 | The walk passed all checks; 0 means update nothing |
| leaf_lvl | input | LVL_W | Level index of the leaf entry (0 = lowest table) |
| is_write | input | 1 | The access was a write |
| ent_in | input | LEVELS*ENTRY_W | Latched entries, level l at bits [l*ENTRY_W +: ENTRY_W] |
| addr_in | input | LEVELS*ADDR_W | Physical address of each entry, packed the same way |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| ent_out | output | LEVELS*ENTRY_W | Latched entries after the flag updates |
| wrote | output | LEVELS | Per-level flag: memory was updated |
| req_valid | output | 1 | Compare-and-swap request pending |
| req_addr | output | ADDR_W | Request address |
| req_cmp | output | ENTRY_W | Expected memory value |
| req_swap | output | ENTRY_W | Value to store on match |
| rsp_valid | input | 1 | Response strobe |
| rsp_data | input | ENTRY_W | Memory value before the operation |

## Verification
A fault in the level counter shows up on the request port as an address out of order, a Dirty flag on the wrong entry, or a missing or extra request. It appears within the operation in which it occurs. A wrong comparison against the response shows up in `wrote` and in the memory model's contents at the next `done`. A latched copy that is not updated or is corrupted shows up on `ent_out` at that same `done`. The memory model flips a bit in an entry just before some requests, so both the success path and the mismatch path are exercised against the same expected state.

// File: rtl/pte_ad_pkg.sv
// Package: shared types for the accessed/dirty updater.
// Assumes: nothing beyond the standard.
package pte_ad_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_WAIT = 2'd2,
        ST_FIN  = 2'd3
    } upd_state_t;
endpackage

// File: rtl/pte_ad_merge.sv
// Module: computes the flag-updated value of one entry and whether it changed.
// Assumes: the flag positions are valid bit indices of ENTRY_W.
module pte_ad_merge #(
    parameter int ENTRY_W = 64,
    parameter int ACC_BIT = 5,
    parameter int DRT_BIT = 6
) (
    input  logic [ENTRY_W-1:0] old_val,
    input  logic               want_dirty,
    output logic [ENTRY_W-1:0] new_val,
    output logic               changed
);
    localparam logic [ENTRY_W-1:0] ACC_MASK = ENTRY_W'(1) << ACC_BIT;
    localparam logic [ENTRY_W-1:0] DRT_MASK = ENTRY_W'(1) << DRT_BIT;

    // Merge the flags and detect a real change.
    always_comb begin
        new_val = old_val | ACC_MASK | (want_dirty ? DRT_MASK : '0);
        changed = (new_val != old_val);
    end
endmodule

// File: rtl/pte_ad_store.sv
// Module: per-level storage of latched entries and their addresses.
// Assumes: load and upd are never high in the same cycle.
module pte_ad_store #(
    parameter int LEVELS  = 4,
    parameter int ENTRY_W = 64,
    parameter int ADDR_W  = 52,
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [LEVELS*ENTRY_W-1:0] ent_in,
    input  logic [LEVELS*ADDR_W-1:0]  addr_in,
    input  logic                      upd,
    input  logic [ENTRY_W-1:0]        upd_val,
    input  logic [LVL_W-1:0]          sel,
    output logic [ENTRY_W-1:0]        sel_ent,
    output logic [ADDR_W-1:0]         sel_addr,
    output logic [LEVELS*ENTRY_W-1:0] ent_flat
);
    logic [ENTRY_W-1:0] ent_q  [LEVELS];
    logic [ADDR_W-1:0]  addr_q [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        // Hold one level's entry: load at start, overwrite on a flag update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g]  <= '0;
                addr_q[g] <= '0;
            end else if (load) begin
                ent_q[g]  <= ent_in[g*ENTRY_W +: ENTRY_W];
                addr_q[g] <= addr_in[g*ADDR_W +: ADDR_W];
            end else if (upd && (sel == LVL_W'(g))) begin
                ent_q[g]  <= upd_val;
            end
        end
        assign ent_flat[g*ENTRY_W +: ENTRY_W] = ent_q[g];
    end

    // Select the entry for the level being processed.
    always_comb begin
        sel_ent  = ent_q[sel];
        sel_addr = addr_q[sel];
    end
endmodule

// File: rtl/pte_ad_updater.sv
// Module: writes Accessed/Dirty flags back to table memory, from the leaf level up
//         to the top level, using one compare-and-swap at a time.
// Assumes: rsp_valid arrives no earlier than the cycle after req_valid is first
//          seen, and only while req_valid is high.
module pte_ad_updater
    import pte_ad_pkg::*;
#(
    parameter int LEVELS  = 4,
    parameter int ENTRY_W = 64,
    parameter int ADDR_W  = 52,
    parameter int ACC_BIT = 5,
    parameter int DRT_BIT = 6,
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      walk_ok,
    input  logic [LVL_W-1:0]          leaf_lvl,
    input  logic                      is_write,
    input  logic [LEVELS*ENTRY_W-1:0] ent_in,
    input  logic [LEVELS*ADDR_W-1:0]  addr_in,
    output logic                      busy,
    output logic                      done,
    output logic [LEVELS*ENTRY_W-1:0] ent_out,
    output logic [LEVELS-1:0]         wrote,
    output logic                      req_valid,
    output logic [ADDR_W-1:0]         req_addr,
    output logic [ENTRY_W-1:0]        req_cmp,
    output logic [ENTRY_W-1:0]        req_swap,
    input  logic                      rsp_valid,
    input  logic [ENTRY_W-1:0]        rsp_data
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    upd_state_t         state;
    logic [LVL_W-1:0]   cur_lvl;
    logic [LVL_W-1:0]   leaf_q;
    logic               wr_q;
    logic               accept;
    logic               upd_now;
    logic               want_dirty;
    logic [ENTRY_W-1:0] sel_ent;
    logic [ADDR_W-1:0]  sel_addr;
    logic [ENTRY_W-1:0] new_val;
    logic               changed;

    // Decode acceptance, store update and Dirty request.
    always_comb begin
        accept     = (state == ST_IDLE) && start;
        upd_now    = (state == ST_EVAL) && changed;
        want_dirty = wr_q && (cur_lvl == leaf_q) && (cur_lvl != TOP_LVL);
    end

    pte_ad_store #(
        .LEVELS (LEVELS),
        .ENTRY_W(ENTRY_W),
        .ADDR_W (ADDR_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .ent_in  (ent_in),
        .addr_in (addr_in),
        .upd     (upd_now),
        .upd_val (new_val),
        .sel     (cur_lvl),
        .sel_ent (sel_ent),
        .sel_addr(sel_addr),
        .ent_flat(ent_out)
    );

    pte_ad_merge #(
        .ENTRY_W(ENTRY_W),
        .ACC_BIT(ACC_BIT),
        .DRT_BIT(DRT_BIT)
    ) merge_i (
        .old_val   (sel_ent),
        .want_dirty(want_dirty),
        .new_val   (new_val),
        .changed   (changed)
    );

    // Sequence the levels and the compare-and-swap requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_lvl  <= '0;
            leaf_q   <= '0;
            wr_q     <= 1'b0;
            wrote    <= '0;
            req_addr <= '0;
            req_cmp  <= '0;
            req_swap <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        leaf_q  <= leaf_lvl;
                        wr_q    <= is_write;
                        cur_lvl <= leaf_lvl;
                        wrote   <= '0;
                        state   <= walk_ok ? ST_EVAL : ST_FIN;
                    end
                end
                ST_EVAL: begin
                    if (changed) begin
                        req_addr <= sel_addr;
                        req_cmp  <= sel_ent;
                        req_swap <= new_val;
                        state    <= ST_WAIT;
                    end else if (cur_lvl == TOP_LVL) begin
                        state <= ST_FIN;
                    end else begin
                        cur_lvl <= cur_lvl + LVL_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_data == req_cmp) begin
                            wrote[cur_lvl] <= 1'b1;
                        end
                        if (cur_lvl == TOP_LVL) begin
                            state <= ST_FIN;
                        end else begin
                            cur_lvl <= cur_lvl + LVL_W'(1);
                            state   <= ST_EVAL;
                        end
                    end
                end
                ST_FIN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the status and request strobes from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        req_valid = (state == ST_WAIT);
    end
endmodule

// File: rtl/pte_ad_updater_chk.sv
// Module: protocol and flag checks for pte_ad_updater, attached by bind.
// Assumes: the same parameters as the checked instance.
module pte_ad_updater_chk #(
    parameter int LEVELS  = 4,
    parameter int ENTRY_W = 64,
    parameter int ADDR_W  = 52,
    parameter int ACC_BIT = 5,
    parameter int DRT_BIT = 6,
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [ENTRY_W-1:0] req_cmp,
    input logic [ENTRY_W-1:0] req_swap,
    input logic               rsp_valid,
    input logic [LVL_W-1:0]   cur_lvl,
    input logic [LEVELS-1:0]  wrote
);
    localparam logic [ENTRY_W-1:0] FLAG_MASK =
        (ENTRY_W'(1) << ACC_BIT) | (ENTRY_W'(1) << DRT_BIT);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_cmp) && $stable(req_swap)));

    assert_flag_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((((req_swap ^ req_cmp) & ~FLAG_MASK) == '0) && req_swap[ACC_BIT]));

    assert_real_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_swap != req_cmp));

    assert_top_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (cur_lvl == TOP_LVL)) |-> (req_swap[DRT_BIT] == req_cmp[DRT_BIT]));

    assert_one_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wrote & ~$past(wrote)) <= 1);

    assert_mark_on_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((wrote & ~$past(wrote)) != '0) |-> $past(rsp_valid));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);
endmodule

bind pte_ad_updater pte_ad_updater_chk #(
    .LEVELS (LEVELS),
    .ENTRY_W(ENTRY_W),
    .ADDR_W (ADDR_W),
    .ACC_BIT(ACC_BIT),
    .DRT_BIT(DRT_BIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_cmp  (req_cmp),
    .req_swap (req_swap),
    .rsp_valid(rsp_valid),
    .cur_lvl  (cur_lvl),
    .wrote    (wrote)
);

// File: tb/pte_ad_updater_tb_top.sv
// Bench: random and directed update operations against a compare-and-swap
//        memory model that can change entries just before a request.
module pte_ad_updater_tb_top;
    localparam int LV = 4;
    localparam int EW = 64;
    localparam int AW = 52;
    localparam logic [EW-1:0] ACC = 64'h20;
    localparam logic [EW-1:0] DRT = 64'h40;
    localparam logic [EW-1:0] FLIP = 64'h200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              walk_ok = 1'b0;
    logic [1:0]        leaf_lvl = '0;
    logic              is_write = 1'b0;
    logic [LV*EW-1:0]  ent_in = '0;
    logic [LV*AW-1:0]  addr_in = '0;
    logic              busy, done, req_valid;
    logic [LV*EW-1:0]  ent_out;
    logic [LV-1:0]     wrote;
    logic [AW-1:0]     req_addr;
    logic [EW-1:0]     req_cmp, req_swap;
    logic              rsp_valid = 1'b0;
    logic [EW-1:0]     rsp_data = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [EW-1:0] b_ent [LV];
    logic [EW-1:0] b_mem [LV];
    logic [AW-1:0] b_addr [LV];
    bit            b_inj [LV];
    int            nreq = 0;
    int            last_idx = -1;
    int            order_bad = 0;

    always #4 clk = ~clk;

    pte_ad_updater dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .walk_ok(walk_ok),
        .leaf_lvl(leaf_lvl), .is_write(is_write), .ent_in(ent_in),
        .addr_in(addr_in), .busy(busy), .done(done), .ent_out(ent_out),
        .wrote(wrote), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmp(req_cmp), .req_swap(req_swap), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Global watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            finish_run();
        end
    end

    // Compare-and-swap memory model with optional concurrent modification (R4).
    always @(negedge clk) begin
        if (rsp_valid) begin
            rsp_valid = 1'b0;
        end else if (req_valid) begin
            int idx;
            idx = -1;
            for (int l = 0; l < LV; l++) if (b_addr[l] == req_addr) idx = l;
            if (idx < 0) begin
                order_bad++;
            end else begin
                if (b_inj[idx]) b_mem[idx] = b_mem[idx] ^ FLIP;
                rsp_data = b_mem[idx];
                if (b_mem[idx] == req_cmp) b_mem[idx] = req_swap;
                if (idx <= last_idx) order_bad++;   // R6 increasing order
                last_idx = idx;
            end
            nreq++;
            rsp_valid = 1'b1;
        end
    end

    task automatic check(string req, logic [EW-1:0] act, logic [EW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Run one operation and compare against the requirement model.
    task automatic run_case(int leaf, bit wr, bit ok, bit poke);
        logic [EW-1:0] e_exp [LV];
        logic [EW-1:0] m_exp [LV];
        logic [LV-1:0] w_exp;
        int            n_exp;
        int            wd;
        // Expected values, R1..R8.
        w_exp = '0; n_exp = 0;
        for (int l = 0; l < LV; l++) begin
            e_exp[l] = b_ent[l];
            m_exp[l] = b_ent[l];
            b_mem[l] = b_ent[l];
        end
        if (ok) begin
            for (int l = leaf; l < LV; l++) begin
                logic [EW-1:0] nv;
                nv = b_ent[l] | ACC | ((wr && l == leaf && l != LV-1) ? DRT : '0);
                if (nv != b_ent[l]) begin
                    e_exp[l] = nv;
                    n_exp++;
                    if (b_inj[l]) m_exp[l] = m_exp[l] ^ FLIP;
                    if (m_exp[l] == b_ent[l]) begin
                        m_exp[l] = nv;
                        w_exp[l] = 1'b1;
                    end
                end
            end
        end
        nreq = 0; last_idx = -1; order_bad = 0;
        @(negedge clk);
        for (int l = 0; l < LV; l++) begin
            ent_in[l*EW +: EW] = b_ent[l];
            addr_in[l*AW +: AW] = b_addr[l];
        end
        leaf_lvl = 2'(leaf); is_write = wr; walk_ok = ok; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", {63'b0, busy}, 64'd1);
        if (poke) begin
            // R10: a second start while busy must be ignored.
            walk_ok = 1'b0; leaf_lvl = 2'd3; is_write = 1'b0; ent_in = '0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!done && wd < 200) begin
            @(negedge clk);
            wd++;
        end
        check("R10 done reached", {63'b0, done}, 64'd1);
        for (int l = 0; l < LV; l++) begin
            check(ok ? "R3 latched entry" : "R5 entry unchanged",
                  ent_out[l*EW +: EW], e_exp[l]);
            check("R4 memory contents", b_mem[l], m_exp[l]);
        end
        check("R8 wrote marks", {60'b0, wrote}, {60'b0, w_exp});
        check("R2 request count", 64'(nreq), 64'(n_exp));
        check("R6 level order", 64'(order_bad), 64'd0);
        @(negedge clk);
        check("R10 done one cycle", {62'b0, done, busy}, 64'd0);
    endtask

    task automatic rand_setup();
        for (int l = 0; l < LV; l++) begin
            b_ent[l] = {$urandom(), $urandom()};
            b_addr[l] = {$urandom(), 15'($urandom()), 2'(l), 3'b000};
            b_inj[l] = ($urandom_range(0, 3) == 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int l = 0; l < LV; l++) b_inj[l] = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset idle", {60'b0, busy, done, req_valid, 1'b0}, 64'd0);
        check("R8 reset marks", {60'b0, wrote}, 64'd0);
        rst_n = 1'b1;

        // R1/R7: clean entries, write with leaf at lowest level.
        rand_setup();
        for (int l = 0; l < LV; l++) begin b_ent[l] &= ~(ACC | DRT); b_inj[l] = 0; end
        run_case(0, 1'b1, 1'b1, 1'b0);
        // R2: all flags already set, no traffic.
        rand_setup();
        for (int l = 0; l < LV; l++) b_ent[l] |= (ACC | DRT);
        run_case(1, 1'b1, 1'b1, 1'b0);
        // R7: top level as leaf never gets Dirty.
        rand_setup();
        for (int l = 0; l < LV; l++) begin b_ent[l] &= ~(ACC | DRT); b_inj[l] = 0; end
        run_case(3, 1'b1, 1'b1, 1'b0);
        // R5: failed walk.
        rand_setup();
        for (int l = 0; l < LV; l++) b_ent[l] &= ~(ACC | DRT);
        run_case(0, 1'b1, 1'b0, 1'b0);
        // R4: every level modified concurrently.
        rand_setup();
        for (int l = 0; l < LV; l++) begin b_ent[l] &= ~(ACC | DRT); b_inj[l] = 1; end
        run_case(1, 1'b0, 1'b1, 1'b0);
        // R10: start while busy.
        rand_setup();
        for (int l = 0; l < LV; l++) begin b_ent[l] &= ~(ACC | DRT); b_inj[l] = 0; end
        run_case(2, 1'b1, 1'b1, 1'b1);
        // Random mix.
        for (int i = 0; i < 300; i++) begin
            rand_setup();
            run_case($urandom_range(0, 3), 1'($urandom()), ($urandom_range(0, 7) != 0), 1'b0);
        end
        finish_run();
    end
endmodule